// File: doc/BRIEF.md
# Three-Wire PLL Programming Serializer

This block loads a frequency synthesizer over a three-wire serial bus made of a clock line, a data line and a latch line. On a start request it sends a settings frame (16 bits), a reference-divider frame (18 bits) and a counter frame (23 bits), in that order. The counter frame carries the main divide value, then the swallow value, then a two-bit address tag. Each frame is sent most significant bit first with no byte padding. After each frame the latch line is pulsed high, and the synthesizer copies the shifted word into the register that the address bits select.

The host places the settings word, the reference word and the two counter values on parallel inputs and pulses `start_i`. The block copies all inputs on the accepted start, so the host may change them at once. A channel change only needs new counter values. In that case `counter_only_i` is raised with the start, and only the counter frame is sent. `busy_o` is high while a sequence runs. A start that arrives while busy is dropped. `done_o` pulses for one cycle when the last latch pulse and its trailing gap are over.

The start input is a plain strobe with no ready line. The host can read `busy_o` low as "ready". A strobe given while busy is lost rather than held back, so there is no back-pressure to honour.

Top module: `pll3w_programmer`

## Requirements
- R1: After reset `busy_o`, `done_o`, `sclk_o`, `latch_o` and `sdata_o` are all 0. With the block idle, the serial clock and the latch line stay low.
- R2: A full sequence sends three frames in a fixed order: first the 16-bit `settings_i` word, then the 18-bit `ref_i` word (for example a reference divide of 800), then the counter frame. Each frame ends with one latch pulse.
- R3: The counter frame is 23 bits. Sent first to last, it carries `n_i[13:0]`, then `a_i[6:0]`, then the address bits 0 and 1.
- R4: Bits go out MSB first. `sdata_o` changes only in the cycle where `sclk_o` falls, or while it is low. It holds steady for the whole high phase.
- R5: `latch_o` is low while a frame's bits are clocked. It rises after the clock falls for the last bit. It stays high for LATCH_HALVES×HALF_DIV system cycles (at least one serial clock period), and `sclk_o` stays low throughout.
- R6: Each high phase of `sclk_o` lasts HALF_DIV system clock cycles.
- R7: A start pulse while `busy_o` is high is ignored. No extra frame is sent, and the running sequence's frames keep their values.
- R8: `done_o` is a one-cycle pulse, given once per sequence in the cycle where `busy_o` falls. By then every frame has been latched and `latch_o` is low.
- R9: A start with `counter_only_i` = 1 sends only the counter frame.
- R10: Inputs are captured on the accepted start. Changing them during a sequence does not alter the frames being sent.
- R11: A start given in the same cycle as `done_o` is accepted, and a new sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| counter_only_i | input | 1 | 1: send only the counter frame |
| settings_i | input | 16 | Settings frame word |
| ref_i | input | 18 | Reference-divider frame word |
| n_i | input | 14 | Main counter value |
| a_i | input | 7 | Swallow counter value |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock, idles low |
| sdata_o | output | 1 | Serial data |
| latch_o | output | 1 | Frame latch pulse |

## Verification
Two events can land in the same cycle: the completion pulse of one sequence and the start of the next. The bench waits for `done_o` and raises `start_i` in that same cycle. It expects `busy_o` to be high one cycle later, and it expects the new frames to match in full. A start given in the middle of a frame, with changed inputs and the counter-only flag set, must leave the running sequence's three frames unchanged.

// File: rtl/pll3w_pkg.sv
package pll3w_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH,
    PH_LATCH,
    PH_GAP
  } phase_t;

  localparam logic [1:0] IDX_SET = 2'd0;
  localparam logic [1:0] IDX_REF = 2'd1;
  localparam logic [1:0] IDX_CNT = 2'd2;
endpackage

// File: rtl/pll3w_tick.sv
module pll3w_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pll3w_shift.sv
module pll3w_shift
  import pll3w_pkg::*;
#(
  parameter int HALF_DIV     = 4,
  parameter int LATCH_HALVES = 2,
  parameter int MAX_W        = 23,
  parameter int LEN_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [MAX_W-1:0] word_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             latch_o,
  output logic             frame_done_o
);
  localparam int LH_W = $clog2(LATCH_HALVES + 1);
  localparam logic [LH_W-1:0] LH_LAST = LH_W'(LATCH_HALVES - 1);

  phase_t           ph_q;
  logic [MAX_W-1:0] sr_q;
  logic [LEN_W-1:0] bits_q;
  logic [LH_W-1:0]  hcnt_q;
  logic             sclk_q, le_q, fdone_q;
  logic             tick;

  pll3w_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (ph_q != PH_IDLE),
    .tick_o(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      sr_q    <= '0;
      bits_q  <= '0;
      hcnt_q  <= '0;
      sclk_q  <= 1'b0;
      le_q    <= 1'b0;
      fdone_q <= 1'b0;
    end else begin
      fdone_q <= 1'b0;
      case (ph_q)
        PH_IDLE: if (load_i) begin
          sr_q   <= word_i;
          bits_q <= len_i;
          ph_q   <= PH_LOW;
        end
        PH_LOW: if (tick) begin
          sclk_q <= 1'b1;
          ph_q   <= PH_HIGH;
        end
        PH_HIGH: if (tick) begin
          sclk_q <= 1'b0;
          if (bits_q == LEN_W'(1)) begin
            le_q   <= 1'b1;
            hcnt_q <= '0;
            ph_q   <= PH_LATCH;
          end else begin
            sr_q   <= sr_q << 1;
            bits_q <= bits_q - 1'b1;
            ph_q   <= PH_LOW;
          end
        end
        PH_LATCH: if (tick) begin
          if (hcnt_q == LH_LAST) begin
            le_q <= 1'b0;
            sr_q <= '0;
            ph_q <= PH_GAP;
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
        PH_GAP: if (tick) begin
          ph_q    <= PH_IDLE;
          fdone_q <= 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign sclk_o       = sclk_q;
  assign sdata_o      = sr_q[MAX_W-1];
  assign latch_o      = le_q;
  assign frame_done_o = fdone_q;
endmodule

// File: rtl/pll3w_seq.sv
module pll3w_seq
  import pll3w_pkg::*;
#(
  parameter int SET_W  = 16,
  parameter int REF_W  = 18,
  parameter int N_W    = 14,
  parameter int A_W    = 7,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 2'b01,
  parameter int MAX_W  = 23,
  parameter int LEN_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             counter_only_i,
  input  logic [SET_W-1:0] settings_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic [N_W-1:0]   n_i,
  input  logic [A_W-1:0]   a_i,
  input  logic             frame_done_i,
  output logic             load_o,
  output logic [MAX_W-1:0] word_o,
  output logic [LEN_W-1:0] len_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int CNT_W = N_W + A_W + ADDR_W;
  localparam int NFR   = 3;

  function automatic int frame_len(input int idx);
    case (idx)
      0:       return SET_W;
      1:       return REF_W;
      default: return CNT_W;
    endcase
  endfunction

  logic [MAX_W-1:0] raw     [NFR];
  logic [MAX_W-1:0] aligned [NFR];
  logic [MAX_W-1:0] cap_q   [NFR];
  logic [1:0]       idx_q;
  logic             busy_q, done_q, load_q;

  assign raw[0] = MAX_W'(settings_i);
  assign raw[1] = MAX_W'(ref_i);
  assign raw[2] = MAX_W'({n_i, a_i, CNT_ADDR});

  for (genvar g = 0; g < NFR; g++) begin : g_align
    localparam int SH = MAX_W - frame_len(g);
    assign aligned[g] = raw[g] << SH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      load_q <= 1'b0;
      idx_q  <= IDX_SET;
      for (int k = 0; k < NFR; k++) cap_q[k] <= '0;
    end else begin
      done_q <= 1'b0;
      load_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          load_q <= 1'b1;
          idx_q  <= counter_only_i ? IDX_CNT : IDX_SET;
          for (int k = 0; k < NFR; k++) cap_q[k] <= aligned[k];
        end
      end else if (frame_done_i) begin
        if (idx_q == IDX_CNT) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q  <= idx_q + 1'b1;
          load_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (idx_q)
      IDX_SET: begin word_o = cap_q[0]; len_o = LEN_W'(SET_W); end
      IDX_REF: begin word_o = cap_q[1]; len_o = LEN_W'(REF_W); end
      default: begin word_o = cap_q[2]; len_o = LEN_W'(CNT_W); end
    endcase
  end

  assign load_o = load_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/pll3w_programmer.sv
module pll3w_programmer #(
  parameter int HALF_DIV     = 4,
  parameter int LATCH_HALVES = 2,
  parameter int SET_W        = 16,
  parameter int REF_W        = 18,
  parameter int N_W          = 14,
  parameter int A_W          = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             counter_only_i,
  input  logic [SET_W-1:0] settings_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic [N_W-1:0]   n_i,
  input  logic [A_W-1:0]   a_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             latch_o
);
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CNT_ADDR = 2'b01;
  localparam int CNT_W = N_W + A_W + ADDR_W;
  localparam int M1    = (SET_W > REF_W) ? SET_W : REF_W;
  localparam int MAX_W = (M1 > CNT_W) ? M1 : CNT_W;
  localparam int LEN_W = $clog2(MAX_W + 1);

  logic             load, fdone;
  logic [MAX_W-1:0] word;
  logic [LEN_W-1:0] len;

  pll3w_seq #(
    .SET_W(SET_W), .REF_W(REF_W), .N_W(N_W), .A_W(A_W),
    .ADDR_W(ADDR_W), .CNT_ADDR(CNT_ADDR), .MAX_W(MAX_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .counter_only_i(counter_only_i),
    .settings_i    (settings_i),
    .ref_i         (ref_i),
    .n_i           (n_i),
    .a_i           (a_i),
    .frame_done_i  (fdone),
    .load_o        (load),
    .word_o        (word),
    .len_o         (len),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  pll3w_shift #(
    .HALF_DIV(HALF_DIV), .LATCH_HALVES(LATCH_HALVES),
    .MAX_W(MAX_W), .LEN_W(LEN_W)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .word_i      (word),
    .len_i       (len),
    .sclk_o      (sclk_o),
    .sdata_o     (sdata_o),
    .latch_o     (latch_o),
    .frame_done_o(fdone)
  );
endmodule

// File: rtl/pll3w_checker.sv
module pll3w_checker #(
  parameter int HALF_DIV     = 4,
  parameter int LATCH_HALVES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sdata,
  input logic latch
);
  logic [15:0] hi_cnt, le_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      le_cnt <= '0;
    end else begin
      hi_cnt <= sclk  ? hi_cnt + 1'b1 : 16'd0;
      le_cnt <= latch ? le_cnt + 1'b1 : 16'd0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !latch));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));

  p_latch_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> !sclk);

  p_latch_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch) |-> (le_cnt == 16'(LATCH_HALVES * HALF_DIV)));

  p_high_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == 16'(HALF_DIV)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !latch && $past(busy)));
endmodule

bind pll3w_programmer pll3w_checker #(
  .HALF_DIV(HALF_DIV), .LATCH_HALVES(LATCH_HALVES)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .busy (busy_o),
  .done (done_o),
  .sclk (sclk_o),
  .sdata(sdata_o),
  .latch(latch_o)
);

// File: tb/pll3w_programmer_tb_top.sv
module pll3w_programmer_tb_top;
  localparam int HALF = 4;
  localparam int LH   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, counter_only_i = 1'b0;
  logic [15:0] settings_i = '0;
  logic [17:0] ref_i = '0;
  logic [13:0] n_i = '0;
  logic [6:0]  a_i = '0;
  logic        busy_o, done_o, sclk_o, sdata_o, latch_o;

  always #2 clk = ~clk;

  pll3w_programmer #(.HALF_DIV(HALF), .LATCH_HALVES(LH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .counter_only_i(counter_only_i),
    .settings_i(settings_i), .ref_i(ref_i), .n_i(n_i), .a_i(a_i),
    .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .latch_o(latch_o)
  );

  typedef struct {
    string       tag;
    int          len;
    logic [31:0] word;
  } frame_t;

  frame_t exp_q[$];
  int checks = 0, fails = 0;
  int frames_seen = 0, done_seen = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: rebuilds frames from the wire and compares with the scoreboard
  logic        prev_sclk = 0, prev_le = 0, cur_bit = 0, data_bad = 0, le_bad = 0;
  logic [31:0] acc = '0;
  int          nbits = 0, hi_cnt = 0, le_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk_o && !prev_sclk) begin
        acc = {acc[30:0], sdata_o};
        cur_bit = sdata_o;
        nbits++;
        if (latch_o) le_bad = 1;
      end
      if (sclk_o && prev_sclk && sdata_o != cur_bit) data_bad = 1;
      if (sclk_o) hi_cnt++;
      if (!sclk_o && prev_sclk) begin
        chk(hi_cnt == HALF, "R6", "high phase cycles", hi_cnt, HALF);
        hi_cnt = 0;
      end
      if (latch_o && !prev_le) begin
        frames_seen++;
        if (exp_q.size() == 0) begin
          chk(0, "R7", "unexpected frame", acc, 0);
        end else begin
          frame_t e;
          logic [31:0] mask;
          e = exp_q.pop_front();
          mask = (32'h1 << e.len) - 1;
          chk(nbits == e.len, e.tag, "frame length", nbits, e.len);
          chk((acc & mask) == e.word, e.tag, "frame bits MSB first", acc & mask, e.word);
          chk(!data_bad, "R4", "data moved in high phase", data_bad, 0);
        end
        acc = '0; nbits = 0; data_bad = 0;
      end
      if (latch_o) begin
        le_cnt++;
        if (sclk_o) le_bad = 1;
      end
      if (!latch_o && prev_le) begin
        chk(le_cnt == LH * HALF && !le_bad, "R5", "latch width / clock quiet",
            le_cnt, LH * HALF);
        le_cnt = 0; le_bad = 0;
      end
      if (done_o) done_seen++;
      prev_sclk = sclk_o;
      prev_le   = latch_o;
    end
  end

  // Driver
  task automatic push(string tag, int len, logic [31:0] w);
    frame_t f;
    f.tag = tag; f.len = len; f.word = w;
    exp_q.push_back(f);
  endtask

  task automatic launch(bit co, logic [15:0] s, logic [17:0] r,
                        logic [13:0] n, logic [6:0] a);
    if (!co) begin
      push("R2", 16, 32'(s));
      push("R2", 18, 32'(r));
    end
    push(co ? "R9" : "R3", 23, 32'({n, a, 2'b01}));
    counter_only_i = co; settings_i = s; ref_i = r; n_i = n; a_i = a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "frames pending at done", exp_q.size(), 0);
    chk(!busy_o && !latch_o, "R8", "busy/latch at done", {busy_o, latch_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int base, dbase;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, sclk_o, latch_o, sdata_o} == 5'b0, "R1", "reset outputs",
        {busy_o, done_o, sclk_o, latch_o, sdata_o}, 0);

    // Full sequence, reference divide 800
    base = frames_seen; dbase = done_seen;
    launch(0, 16'hA5C3, 18'd800, 14'd2495, 7'd60);
    wait_done();
    chk(frames_seen - base == 3, "R2", "frames in full sequence", frames_seen - base, 3);
    @(negedge clk);
    chk(!done_o, "R8", "done held past one cycle", done_o, 0);

    // Counter frame only
    base = frames_seen;
    launch(1, 16'hFFFF, 18'h3FFFF, 14'h2AAA, 7'h55);
    wait_done();
    chk(frames_seen - base == 1, "R9", "frames in counter-only", frames_seen - base, 1);

    // Start while busy with changed inputs
    base = frames_seen;
    launch(0, 16'h1234, 18'h2ABCD, 14'h1FFF, 7'h7F);
    repeat (40) @(negedge clk);
    chk(busy_o, "R7", "busy mid sequence", busy_o, 1);
    counter_only_i = 1; settings_i = 16'h0F0F; ref_i = 18'h11111;
    n_i = 14'h0001; a_i = 7'h00;   // R10: these must not reach the wire
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk(frames_seen - base == 3, "R7", "frames after ignored start", frames_seen - base, 3);

    // Start in the done cycle
    base = frames_seen;
    launch(0, 16'h0001, 18'h00001, 14'h0001, 7'h01);
    chk(busy_o, "R11", "start in done cycle taken", busy_o, 0 + 1);
    wait_done();
    chk(frames_seen - base == 3, "R11", "frames after back-to-back", frames_seen - base, 3);

    // All-zero counter values, only the address bits set
    launch(1, 16'h0, 18'h0, 14'h0, 7'h0);
    wait_done();
    @(negedge clk);
    chk(done_seen - dbase == 5, "R8", "done pulses total", done_seen - dbase, 5);

    repeat (20) @(negedge clk);
    chk(!sclk_o && !latch_o && !busy_o, "R1", "idle lines low",
        {sclk_o, latch_o, busy_o}, 0);
    summary();
  end
endmodule